// File: doc/BRIEF.md
# Edge-Latched SRAM Cycle Controller

This block sits between a host and an asynchronous static RAM whose address is captured inside the memory on the falling edge of its chip enable. The host hands over one command at a time: read or write, an address and write data. The controller then runs the memory cycle on the chip-enable, write-enable, address and data pins. The memory data bus is split into a driven output with an enable and a sampled input, so a bus-level wrapper can form the shared pins.

Every minimum interval of the memory is a nanosecond parameter. Each one is turned into a clock-cycle count by ceiling division by the clock period when the design is elaborated. A cycle has five phases: idle, a setup phase with the address on the pins and chip enable high, an active phase with chip enable low, a final capture cycle, and a precharge phase with chip enable high. The controller takes a new command only after precharge has covered the high-width, bus-release and total-cycle-time minimums.

Commands come in on a valid/ready pair. A command moves when `req_valid` and `req_ready` are both high at a rising edge. The host must hold the command fields stable while `req_valid` waits on a low `req_ready`. The response side has no back-pressure: read data comes back with a one-cycle `rsp_valid` pulse that the host must take in that cycle.

Top module: `sramc_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A command is taken on a rising edge with `req_valid` and `req_ready` both high. `req_valid` and the command fields are ignored while `req_ready` is low.
- R2: For each command, chip enable (active low) stays low for LOW cycles in a row. LOW is the largest ceiling-converted value among the chip-enable low width, access time, write-enable pulse, lead and lag, address hold and data setup, and it is never below 2. With the defaults (8 ns clock) LOW is 15.
- R3: After chip enable rises, it stays high for at least the larger of the converted high width and bus-release time (default 7 cycles). Two successive chip-enable falls are at least the converted cycle time apart (default 22 cycles). `req_ready` returns SETUP+LOW+PRE cycles after the accepting edge (default 1+15+7 = 23).
- R4: The memory address equals the accepted command's address. It is on the pins for at least one cycle before chip enable falls and stays stable for every cycle chip enable is low.
- R5: In a write, write enable (active low) falls in the same cycle as chip enable and rises in the same cycle as chip enable. It is never low while chip enable is high or during a read.
- R6: The data driver is enabled only for writes, from the setup phase until chip enable rises. It is never enabled while chip enable is low and write enable is high. Data written at an address is what a later read of that address returns.
- R7: A read samples the memory input at the clock edge that ends the last chip-enable-low cycle. In the next cycle `rsp_valid` is high for exactly one cycle with `rsp_rdata` holding the sampled value. With the defaults, this is the 17th falling clock edge after the accepting edge.
- R8: A write produces no `rsp_valid` pulse.
- R9: During reset, chip enable and write enable are high (inactive), the data driver is off and `rsp_valid` is low. After reset, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Controller idle, command can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Command address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DW | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low, falling edge latches the address |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data toward the memory |
| mem_dout_en | output | 1 | Enable for the data driver toward the memory |
| mem_din | input | DW | Data from the memory |

## Verification
A wrong phase or a mis-loaded interval counter shows at the pins within one memory cycle. It appears as a chip-enable low or high run of the wrong length, or a `req_ready` that comes back early or late against the count derived from the nanosecond parameters. An early capture returns wrong data: the bench memory drives inverted data until the access time has passed, so the wrong value appears in `rsp_rdata` in the cycle after the capture edge. A latched command register that is corrupted or overwritten while busy shows as a read-back mismatch on a later read. A driver or write-enable decode error shows as bus contention or a write-enable edge that does not line up with a chip-enable edge, in the same cycle it happens.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_CAPTURE,
    ST_PRE
  } seq_state_t;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sramc_interval_timer.sv
module sramc_interval_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sramc_cycle_seq.sv
module sramc_cycle_seq
  import sramc_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned ACT_CYC   = 14,
  parameter int unsigned PRE_CYC   = 7,
  parameter int unsigned CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          tmr_done,
  output seq_state_t    state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);
  seq_state_t nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = CW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_done) begin
        nxt = ST_ACTIVE; tmr_load = 1'b1; tmr_val = CW'(ACT_CYC - 1);
      end
      ST_ACTIVE: if (tmr_done) nxt = ST_CAPTURE;
      ST_CAPTURE: begin
        nxt = ST_PRE; tmr_load = 1'b1; tmr_val = CW'(PRE_CYC - 1);
      end
      ST_PRE: if (tmr_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sramc_rd_capture.sv
module sramc_rd_capture #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= strobe;
      if (strobe) rsp_rdata <= din;
    end
  end
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned AW              = 10,
  parameter int unsigned DW              = 4,
  parameter int unsigned CLK_NS          = 8,
  parameter int unsigned T_ADDR_SETUP_NS = 0,
  parameter int unsigned T_ADDR_HOLD_NS  = 40,
  parameter int unsigned T_CE_LOW_NS     = 120,
  parameter int unsigned T_CE_HIGH_NS    = 50,
  parameter int unsigned T_CYCLE_NS      = 170,
  parameter int unsigned T_ACCESS_NS     = 120,
  parameter int unsigned T_WE_PULSE_NS   = 120,
  parameter int unsigned T_WE_LEAD_NS    = 120,
  parameter int unsigned T_WE_LAG_NS     = 120,
  parameter int unsigned T_DATA_SETUP_NS = 50,
  parameter int unsigned T_BUS_OFF_NS    = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);
  localparam int unsigned SETUP_CYC = max2(1, ns_to_cyc(T_ADDR_SETUP_NS, CLK_NS));
  localparam int unsigned LOW_A = max2(ns_to_cyc(T_CE_LOW_NS, CLK_NS), ns_to_cyc(T_ACCESS_NS, CLK_NS));
  localparam int unsigned LOW_W = max2(ns_to_cyc(T_WE_PULSE_NS, CLK_NS),
                                  max2(ns_to_cyc(T_WE_LEAD_NS, CLK_NS), ns_to_cyc(T_WE_LAG_NS, CLK_NS)));
  localparam int unsigned LOW_H = max2(ns_to_cyc(T_ADDR_HOLD_NS, CLK_NS), ns_to_cyc(T_DATA_SETUP_NS, CLK_NS));
  localparam int unsigned LOW_CYC  = max2(2, max2(LOW_A, max2(LOW_W, LOW_H)));
  localparam int unsigned ACT_CYC  = LOW_CYC - 1;
  localparam int unsigned HIGH_CYC = max2(ns_to_cyc(T_CE_HIGH_NS, CLK_NS), ns_to_cyc(T_BUS_OFF_NS, CLK_NS));
  localparam int unsigned CYC_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int unsigned PRE_REST = (CYC_CYC > LOW_CYC + SETUP_CYC + 1) ? CYC_CYC - LOW_CYC - SETUP_CYC - 1 : 0;
  localparam int unsigned PRE_CYC  = max2(max2(1, HIGH_CYC), PRE_REST);
  localparam int unsigned CW       = $clog2(max2(max2(SETUP_CYC, ACT_CYC), PRE_CYC) + 1);

  seq_state_t    st;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept, ce_active;

  sramc_cycle_seq #(
    .SETUP_CYC(SETUP_CYC), .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tmr_done(tmr_done),
    .state(st), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sramc_interval_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign ce_active   = (st == ST_ACTIVE) || (st == ST_CAPTURE);
  assign mem_ce_n    = !ce_active;
  assign mem_we_n    = !(ce_active && wr_q);
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = wr_q && (ce_active || (st == ST_SETUP));

  sramc_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .strobe((st == ST_CAPTURE) && !wr_q),
    .din(mem_din), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sramc_ctrl_checker.sv
module sramc_ctrl_checker #(
  parameter int unsigned AW       = 10,
  parameter int unsigned LOW_CYC  = 15,
  parameter int unsigned HIGH_CYC = 7,
  parameter int unsigned CYC_CYC  = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dout_en
);
  int unsigned low_cnt, high_cnt, since_fall;
  logic        ce_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt    <= 0;
      high_cnt   <= 1000;
      since_fall <= 1000;
      ce_prev    <= 1'b1;
    end else begin
      ce_prev  <= mem_ce_n;
      low_cnt  <= mem_ce_n ? 0 : low_cnt + 1;
      high_cnt <= !mem_ce_n ? 0 : ((high_cnt < 1000) ? high_cnt + 1 : high_cnt);
      if (ce_prev && !mem_ce_n) since_fall <= 1;
      else if (since_fall < 1000) since_fall <= since_fall + 1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);
  p_ce_low_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_n && !ce_prev) |-> (low_cnt >= LOW_CYC));
  p_ce_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && ce_prev) |-> (high_cnt >= HIGH_CYC));
  p_cycle_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && ce_prev) |-> (since_fall >= CYC_CYC));
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> $stable(mem_addr));
  p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_we_fall_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $fell(mem_ce_n));
  p_we_rise_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && mem_we_n) |-> !mem_dout_en);
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sramc_ctrl sramc_ctrl_checker #(
  .AW(AW), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .CYC_CYC(CYC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout_en(mem_dout_en)
);

// File: tb/tb_sramc_ctrl.sv
module tb_sramc_ctrl;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int TCK = 8;
  localparam int LOW_N  = (120 + TCK - 1) / TCK;
  localparam int HIGH_N = (50 + TCK - 1) / TCK;
  localparam int CYC_N  = (170 + TCK - 1) / TCK;
  localparam int PRE_N  = (HIGH_N > CYC_N - LOW_N - 2) ? HIGH_N : CYC_N - LOW_N - 2;
  localparam int RSP_N   = 1 + LOW_N + 1;
  localparam int READY_N = 1 + LOW_N + PRE_N + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_dout_en;
  logic [DW-1:0] rsp_rdata, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  int vectors = 0, fails = 0;
  int vio_low = 0, vio_high = 0, vio_cyc = 0, vio_addr = 0, vio_we = 0, vio_drv = 0;

  always #(TCK/2) clk = ~clk;

  sramc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // behavioural memory with timing monitors
  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] exp_mem [1<<AW];
  logic [AW-1:0] lat_a = '0;
  logic prev_ce = 1'b1;
  int lowcnt = 0, hicnt = 1000, since = 1000, welow = 0;

  initial for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; exp_mem[i] = '0; end

  assign mem_din = (!mem_ce_n && !prev_ce && lowcnt >= LOW_N - 1) ? mem[lat_a] : ~mem[lat_a];

  always @(posedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && mem_ce_n) vio_we++;
      if (!mem_ce_n && mem_we_n && mem_dout_en) vio_drv++;
      if (!mem_ce_n) begin
        if (prev_ce) begin
          if (hicnt < HIGH_N) vio_high++;
          if (since < CYC_N) vio_cyc++;
          lat_a <= mem_addr; lowcnt <= 1; since <= 1; welow <= !mem_we_n ? 1 : 0;
        end else begin
          if (mem_addr != lat_a) vio_addr++;
          lowcnt <= lowcnt + 1; since <= since + 1;
          if (!mem_we_n) welow <= welow + 1;
        end
        if (!mem_we_n) begin
          if (!mem_dout_en) vio_drv++;
          mem[mem_addr] <= mem_dout;
        end
        hicnt <= 0;
      end else begin
        if (!prev_ce) begin
          if (lowcnt < LOW_N) vio_low++;
          if (welow != 0 && welow != lowcnt) vio_we++;
        end
        hicnt <= hicnt + 1; since <= since + 1;
      end
      prev_ce <= mem_ce_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // called at a falling edge with the controller idle
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit hold);
    int busy_ready = 0, rsp_seen = 0, rsp_at = 0;
    logic [DW-1:0] got = '0;
    chk(req_ready === 1'b1, "R1 ready while idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    if (wr) exp_mem[a] = d;
    for (int n = 1; n <= READY_N; n++) begin
      @(negedge clk);
      if (n == 1) begin req_valid = hold; req_write = ~wr; req_addr = ~a; req_wdata = ~d; end
      if (n == READY_N - 1) req_valid = 1'b0;
      if (n < READY_N && req_ready) busy_ready++;
      if (rsp_valid) begin rsp_seen++; rsp_at = n; got = rsp_rdata; end
    end
    chk(busy_ready == 0, "R1 ready low while busy", busy_ready, 0);
    chk(req_ready === 1'b1, "R3 ready after precharge", int'(req_ready), 1);
    if (wr) chk(rsp_seen == 0, "R8 no response for write", rsp_seen, 0);
    else begin
      chk(rsp_seen == 1 && rsp_at == RSP_N, "R7 response timing", rsp_at, RSP_N);
      chk(got == exp_mem[a], "R7 read data", int'(got), int'(exp_mem[a]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_ce_n === 1'b1 && mem_we_n === 1'b1, "R9 strobes idle in reset", {mem_ce_n, mem_we_n}, 3);
    chk(mem_dout_en === 1'b0 && rsp_valid === 1'b0, "R9 driver and response off", {mem_dout_en, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready after reset", int'(req_ready), 1);
    // directed corners
    do_op(1'b1, '0, 4'h5, 1'b0);
    do_op(1'b1, '1, 4'hA, 1'b1);
    do_op(1'b0, '0, 4'h0, 1'b1);
    do_op(1'b0, '1, 4'h0, 1'b0);
    do_op(1'b1, 10'd3, 4'hF, 1'b0);
    do_op(1'b0, 10'd3, 4'h0, 1'b0);
    do_op(1'b0, 10'd7, 4'h0, 1'b0);
    do_op(1'b1, 10'd3, 4'h0, 1'b0);
    do_op(1'b0, 10'd3, 4'h0, 1'b1);
    // constrained random over a small address window to get read-after-write hits
    for (int k = 0; k < 160; k++) begin
      do_op(1'($urandom % 2), AW'($urandom % 24), DW'($urandom), 1'($urandom % 2));
    end
    chk(vio_low == 0, "R2 chip enable low width", vio_low, 0);
    chk(vio_high == 0, "R3 chip enable high width", vio_high, 0);
    chk(vio_cyc == 0, "R3 cycle time", vio_cyc, 0);
    chk(vio_addr == 0, "R4 address stable while enabled", vio_addr, 0);
    chk(vio_we == 0, "R5 write enable framing", vio_we, 0);
    chk(vio_drv == 0, "R6 data driver use", vio_drv, 0);
    summary();
    $finish;
  end
endmodule